// File: doc/BRIEF.md
# Dual-Channel Sample Capture Double Buffer

This block gathers 8-bit samples from two converter channels into per-channel pairs of 512-byte banks. A channel stores one byte each time its sample tick arrives while capture is enabled. When the bank being written holds 512 bytes, it is marked full and the channel moves on to its other bank. The full bank then waits for the host, which drains it over a single shared byte port.

Readout only moves when the readout mode input is high. It always serves the lowest-numbered channel that has a full bank. When a channel has two full banks, the one filled first goes first. Exactly 512 bytes come out, one per strobe, and the bank becomes empty after its last byte. One aggregate flag reports whether any of the four banks is full, so a status poll can decide whether a readout is worth starting.

If a channel fills both banks before the host drains one, further samples on that channel are discarded and a sticky per-channel overflow flag is raised. A channel index, a bank index and a byte counter show which bank is being drained and how far the drain has got.

Top module: `dual_cap_buf`

## Requirements
- R1: After reset every bank is empty, so `any_full`, `ovf`, `rd_valid` and `rd_cnt` are all zero.
- R2: Bytes captured on a channel are read back in capture order: the k-th strobe of a drain returns the k-th byte stored in that bank.
- R3: While `cap_en` is low, sample ticks store nothing and move no bank pointer.
- R4: `any_full` stays low after 511 stored bytes and is high in the cycle after the 512th byte is stored.
- R5: `any_full` is high exactly when at least one of the four banks is full, and it returns low once all full banks have been drained.
- R6: After a bank fills, the next 512 bytes of that channel go to its other bank. When both banks of a channel are full, the bank filled first is drained first.
- R7: A tick that arrives while both banks of its channel are full is dropped: the stored data is unchanged. The channel's bit in `ovf` (bit n for channel n) is set and stays set until reset. Capture resumes at byte 0 of a bank once that bank is drained.
- R8: When the block is not in a drain, `rd_ch` names the lowest-numbered channel with a full bank. The drain serves that channel first.
- R9: A drain delivers exactly 512 bytes. `rd_cnt` gives the number of bytes already delivered from the current bank (0 to 511). After the 512th byte the bank is empty and `rd_cnt` returns to 0.
- R10: A strobe is ignored when `rd_mode` is low, or when no bank is full and no drain is in progress. It then raises no `rd_valid` and leaves `rd_cnt` unchanged.
- R11: An accepted strobe raises `rd_valid` in the next cycle, with the byte on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable (start/stop) |
| smp_tick | input | 2 | Per-channel sample strobe, bit n for channel n |
| smp_data | input | 16 | Sample bytes, channel n in bits [8n+7:8n] |
| rd_mode | input | 1 | Readout command active |
| rd_stb | input | 1 | Request one byte from the shared port |
| rd_data | output | 8 | Byte read out |
| rd_valid | output | 1 | `rd_data` holds the byte for the previous accepted strobe |
| rd_ch | output | 1 | Channel being drained, or next to be drained |
| rd_bank | output | 1 | Bank index being drained, or next to be drained |
| rd_cnt | output | 9 | Bytes already delivered from the current bank |
| any_full | output | 1 | At least one bank is full |
| ovf | output | 2 | Sticky per-channel overflow flags |

## Verification
The first corner case is the fill boundary. A design off by one in the pointer would raise the full flag after 511 bytes or after 513, and the check at exactly 511 and 512 bytes catches either. Priority is tested by filling channel 1 before channel 0: a design that serves banks in fill order rather than by channel number would return channel 1's bytes first. Overflow is provoked by filling both banks and ticking more. A design that overwrites instead of dropping would corrupt the first bank, and one that picks the wrong bank would return the newer data first. Strobes outside readout mode, and strobes with nothing full, are sent as well; a design that accepted them would raise `rd_valid` or advance the byte counter.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
   typedef enum logic {
      RD_IDLE  = 1'b0,
      RD_DRAIN = 1'b1
   } rd_state_e;

   localparam int BANKS_PER_CH = 2;
endpackage

// File: rtl/dcb_bank_ram.sv
module dcb_bank_ram #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_q
);
   localparam int WORDS = 2 ** ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_q <= mem[rd_addr];
   end
endmodule

// File: rtl/dcb_lane.sv
module dcb_lane #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 512,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              tick,
   input  logic [DATA_W-1:0] din,
   input  logic              free,
   input  logic              free_bank,
   output logic              wr_en,
   output logic [PTR_W:0]    wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [1:0]        full,
   output logic              pick_bank,
   output logic              ovf
);
   logic [PTR_W-1:0] wptr;
   logic             wbank;
   logic [1:0]       full_q, full_nxt;
   logic             ovf_q;
   logic             take, blocked, wr_fire, at_end;

   assign take    = cap_en && tick;
   assign blocked = full_q[wbank];
   assign wr_fire = take && !blocked;
   assign at_end  = (wptr == PTR_W'(DEPTH - 1));

   always_comb begin
      full_nxt = full_q;
      if (wr_fire && at_end) full_nxt[wbank] = 1'b1;
      if (free) full_nxt[free_bank] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr   <= '0;
         wbank  <= 1'b0;
         full_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         full_q <= full_nxt;
         if (take && blocked) ovf_q <= 1'b1;
         if (wr_fire) begin
            if (at_end) begin
               wptr  <= '0;
               wbank <= ~wbank;
            end else begin
               wptr <= wptr + 1'b1;
            end
         end
      end
   end

   assign wr_en     = wr_fire;
   assign wr_addr   = {wbank, wptr};
   assign wr_data   = din;
   assign full      = full_q;
   // the active bank is full only when both are; it was then filled first
   assign pick_bank = full_q[wbank] ? wbank : ~wbank;
   assign ovf       = ovf_q;

   assert_drop_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && blocked) |=> ovf);
   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_gate_holds_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> ($stable(wptr) && $stable(wbank)));
   assert_free_only_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      free |-> full_q[free_bank]);
endmodule

// File: rtl/dcb_reader.sv
module dcb_reader
   import dcb_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DEPTH  = 512,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int CNT_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_mode,
   input  logic              rd_stb,
   input  logic [NUM_CH-1:0] ch_full,
   input  logic [NUM_CH-1:0] ch_pick_bank,
   output logic              accept,
   output logic [CH_W-1:0]   cur_ch,
   output logic              cur_bank,
   output logic [CNT_W-1:0]  cnt,
   output logic [NUM_CH-1:0] free_vec
);
   rd_state_e        state;
   logic [CH_W-1:0]  sel_ch, pick_ch;
   logic             sel_bank;
   logic             busy, last;

   always_comb begin
      pick_ch = '0;
      for (int c = NUM_CH - 1; c >= 0; c--)
         if (ch_full[c]) pick_ch = CH_W'(c);
   end

   assign busy     = (state == RD_DRAIN);
   assign cur_ch   = busy ? sel_ch : pick_ch;
   assign cur_bank = busy ? sel_bank : ch_pick_bank[pick_ch];
   assign accept   = rd_mode && rd_stb && (busy || (|ch_full));
   assign last     = (cnt == CNT_W'(DEPTH - 1));

   always_comb begin
      for (int c = 0; c < NUM_CH; c++)
         free_vec[c] = accept && last && (cur_ch == CH_W'(c));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= RD_IDLE;
         cnt      <= '0;
         sel_ch   <= '0;
         sel_bank <= 1'b0;
      end else if (accept) begin
         if (last) begin
            state <= RD_IDLE;
            cnt   <= '0;
         end else begin
            state    <= RD_DRAIN;
            cnt      <= cnt + 1'b1;
            sel_ch   <= cur_ch;
            sel_bank <= cur_bank;
         end
      end
   end

   assert_exact_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && last) |=> (!busy && cnt == '0));
   assert_one_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(free_vec));
   assert_start_on_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !busy) |-> ch_full[cur_ch]);
   assert_lowest_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !busy && cur_ch != '0) |-> !ch_full[0]);
   assert_no_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_mode |=> $stable(cnt));
endmodule

// File: rtl/dual_cap_buf.sv
module dual_cap_buf #(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 2,
   parameter int DEPTH  = 512,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int CNT_W = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap_en,
   input  logic [NUM_CH-1:0]        smp_tick,
   input  logic [NUM_CH*DATA_W-1:0] smp_data,
   input  logic                     rd_mode,
   input  logic                     rd_stb,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_valid,
   output logic [CH_W-1:0]          rd_ch,
   output logic                     rd_bank,
   output logic [CNT_W-1:0]         rd_cnt,
   output logic                     any_full,
   output logic [NUM_CH-1:0]        ovf
);
   localparam int ADDR_W = CNT_W + 1;

   initial begin
      assert (DEPTH >= 2 && (2 ** CNT_W) == DEPTH)
         else $error("DEPTH must be a power of two of at least 2");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (NUM_CH >= 1) else $error("NUM_CH must be at least 1");
   end

   logic [NUM_CH-1:0] ch_full, ch_pick_bank, free_vec;
   logic              accept, cur_bank;
   logic [CH_W-1:0]   cur_ch, ch_q;
   logic [CNT_W-1:0]  cnt;
   logic              valid_q;
   logic [DATA_W-1:0] q_arr [NUM_CH];
   logic [1:0]        lane_full [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic              wr_en;
      logic [ADDR_W-1:0] wr_addr;
      logic [DATA_W-1:0] wr_data;

      dcb_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .cap_en    (cap_en),
         .tick      (smp_tick[c]),
         .din       (smp_data[c*DATA_W +: DATA_W]),
         .free      (free_vec[c]),
         .free_bank (cur_bank),
         .wr_en     (wr_en),
         .wr_addr   (wr_addr),
         .wr_data   (wr_data),
         .full      (lane_full[c]),
         .pick_bank (ch_pick_bank[c]),
         .ovf       (ovf[c])
      );

      dcb_bank_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
         .clk     (clk),
         .wr_en   (wr_en),
         .wr_addr (wr_addr),
         .wr_data (wr_data),
         .rd_en   (accept && (cur_ch == CH_W'(c))),
         .rd_addr ({cur_bank, cnt}),
         .rd_q    (q_arr[c])
      );

      assign ch_full[c] = |lane_full[c];
   end

   dcb_reader #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_reader (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_mode      (rd_mode),
      .rd_stb       (rd_stb),
      .ch_full      (ch_full),
      .ch_pick_bank (ch_pick_bank),
      .accept       (accept),
      .cur_ch       (cur_ch),
      .cur_bank     (cur_bank),
      .cnt          (cnt),
      .free_vec     (free_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ch_q    <= '0;
      end else begin
         valid_q <= accept;
         if (accept) ch_q <= cur_ch;
      end
   end

   assign rd_data  = q_arr[ch_q];
   assign rd_valid = valid_q;
   assign rd_ch    = cur_ch;
   assign rd_bank  = cur_bank;
   assign rd_cnt   = cnt;
   assign any_full = |ch_full;

   assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode && rd_stb && any_full) |=> rd_valid);
   assert_idle_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_mode |=> !rd_valid);
   assert_empty_no_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_full && rd_cnt == '0) |=> !rd_valid);
endmodule

// File: tb/sim_dual_cap_buf.sv
module sim_dual_cap_buf;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 512;

   typedef struct packed {
      logic [7:0] ch;
      logic [7:0] seed;
      logic [7:0] step;
   } vec_t;

   localparam vec_t VEC [4] = '{
      '{ch: 8'd0, seed: 8'h00, step: 8'h01},
      '{ch: 8'd1, seed: 8'h80, step: 8'h03},
      '{ch: 8'd0, seed: 8'h55, step: 8'hff},
      '{ch: 8'd1, seed: 8'h11, step: 8'h07}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cap_en;
   logic [1:0]  smp_tick;
   logic [15:0] smp_data;
   logic        rd_mode, rd_stb;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic [0:0]  rd_ch;
   logic        rd_bank;
   logic [8:0]  rd_cnt;
   logic        any_full;
   logic [1:0]  ovf;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_cap_buf u0 (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .smp_tick(smp_tick),
      .smp_data(smp_data), .rd_mode(rd_mode), .rd_stb(rd_stb),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_ch(rd_ch),
      .rd_bank(rd_bank), .rd_cnt(rd_cnt), .any_full(any_full), .ovf(ovf)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic feed(input int ch, input logic [7:0] seed, input logic [7:0] step, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_tick = '0;
         smp_tick[ch] = 1'b1;
         smp_data[ch*8 +: 8] = seed + 8'(i) * step;
      end
      @(negedge clk);
      smp_tick = '0;
   endtask

   task automatic drain(input string tag, input logic [7:0] seed, input logic [7:0] step, input int n);
      logic [7:0] expb;
      int err = 0;
      logic [7:0] first_act = '0, first_exp = '0;
      rd_mode = 1'b1;
      @(negedge clk);
      rd_stb = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         expb = seed + 8'(i) * step;
         if (!rd_valid || rd_data !== expb) begin
            if (err == 0) begin
               first_act = rd_data;
               first_exp = expb;
            end
            err++;
         end
         if (i == n - 1) rd_stb = 1'b0;
      end
      chk(tag, {24'd0, (err == 0) ? first_exp : first_act}, {24'd0, first_exp});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R1 act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cap_en = 1'b0; smp_tick = '0; smp_data = '0;
      rd_mode = 1'b0; rd_stb = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 any_full", 32'(any_full), 32'd0);
      chk("R1 ovf", 32'(ovf), 32'd0);
      chk("R1 rd_valid", 32'(rd_valid), 32'd0);
      chk("R1 rd_cnt", 32'(rd_cnt), 32'd0);
      cap_en = 1'b1;

      // table: fill one bank, check flag and channel, drain and compare
      foreach (VEC[k]) begin
         feed(int'(VEC[k].ch), VEC[k].seed, VEC[k].step, DEPTH);
         chk("R4 full after 512", 32'(any_full), 32'd1);
         chk("R8 rd_ch", 32'(rd_ch), 32'(VEC[k].ch));
         drain("R2 R9 R11 vector data", VEC[k].seed, VEC[k].step, DEPTH);
         chk("R5 empty after drain", 32'(any_full), 32'd0);
         chk("R9 cnt back to 0", 32'(rd_cnt), 32'd0);
      end

      // R10: strobe with nothing full
      rd_mode = 1'b1;
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
      chk("R10 empty strobe valid", 32'(rd_valid), 32'd0);
      chk("R10 empty strobe cnt", 32'(rd_cnt), 32'd0);
      rd_mode = 1'b0;

      // R3: capture disabled
      cap_en = 1'b0;
      feed(0, 8'hc0, 8'h01, 600);
      chk("R3 disabled no full", 32'(any_full), 32'd0);
      cap_en = 1'b1;

      // R4 boundary
      feed(0, 8'h20, 8'h01, DEPTH - 1);
      chk("R4 511 not full", 32'(any_full), 32'd0);
      feed(0, 8'h20 + 8'(DEPTH - 1), 8'h01, 1);
      chk("R4 512 full", 32'(any_full), 32'd1);

      // R10: strobe outside readout mode
      rd_mode = 1'b0;
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
      chk("R10 no mode valid", 32'(rd_valid), 32'd0);
      chk("R10 no mode cnt", 32'(rd_cnt), 32'd0);

      // split drain: counter mid-way, disabled samples absent (R3)
      drain("R3 R2 first part", 8'h20, 8'h01, 100);
      chk("R9 cnt mid drain", 32'(rd_cnt), 32'd100);
      chk("R9 rd_ch mid drain", 32'(rd_ch), 32'd0);
      drain("R9 rest of bank", 8'h20 + 8'd100, 8'h01, DEPTH - 100);
      chk("R5 empty after split drain", 32'(any_full), 32'd0);

      // R8 priority: channel 1 fills first
      feed(1, 8'h40, 8'h01, DEPTH);
      feed(0, 8'h90, 8'h01, DEPTH);
      chk("R8 lowest channel chosen", 32'(rd_ch), 32'd0);
      drain("R8 channel 0 first", 8'h90, 8'h01, DEPTH);
      chk("R8 then channel 1", 32'(rd_ch), 32'd1);
      drain("R8 channel 1 data", 8'h40, 8'h01, DEPTH);
      chk("R5 both drained", 32'(any_full), 32'd0);

      // R6 / R7: both banks full, then overflow
      feed(0, 8'h01, 8'h02, DEPTH);
      feed(0, 8'h07, 8'h05, DEPTH);
      chk("R7 no ovf yet", 32'(ovf), 32'd0);
      feed(0, 8'haa, 8'h01, 5);
      chk("R7 ovf set ch0 only", 32'(ovf), 32'd1);
      drain("R6 R7 older bank first", 8'h01, 8'h02, DEPTH);
      drain("R6 second bank", 8'h07, 8'h05, DEPTH);
      chk("R7 ovf sticky", 32'(ovf), 32'd1);
      chk("R5 empty after both", 32'(any_full), 32'd0);
      feed(0, 8'h33, 8'h01, DEPTH);
      drain("R7 capture resumes", 8'h33, 8'h01, DEPTH);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule